// File: doc/BRIEF.md
# Self-Timed Nonvolatile Memory Erase Controller

This block holds a 16-bit memory control word whose top bit starts an operation. Software writes an operation code with the top bit set. The controller decodes the code and holds the top bit high for a fixed number of cycles that depends on the kind of erase. When that time is up, the controller clears the chosen regions of a modelled memory and drops the top bit by itself. The lower 15 bits of the control word stay as written.

The memory is modelled as one "programmed" flag per region:
- code pages, of which the lowest `NSEC` pages form the secure segment and the rest form the general segment;
- executive pages;
- configuration bytes, where byte 0 protects the general segment and byte 1 protects the secure segment;
- one identity flag that no erase may clear.

A separate address register selects the page or the configuration byte for single-item erases. Its value is captured when an operation starts. A `fill` input stands in for earlier programming: it marks every region as programmed.

Top module: `nvm_erase_ctrl`

## Requirements
- R1: After reset, `ctl_q` is 0, `busy` and `err` are 0, and every region flag and `id_q` are 0.
- R2: When idle, a control write with bit 15 clear stores the word in `ctl_q`, starts nothing and leaves every flag unchanged.
- R3: When idle, a control write with bit 15 set starts an operation. `busy` equals `ctl_q[15]`. Bit 15 clears itself when the operation ends, and `ctl_q[14:0]` keeps the written code.
- R4: Bit 15 stays set for `T_PAGE` cycles for codes 0x4042 and 0x4040, for `T_SEG` cycles for codes 0x404D and 0x404C, and for `T_CHIP` cycles for code 0x404F. The codes are taken from bits 14:0 of the control word.
- R5: While `busy` is 1, control writes and `fill` have no effect.
- R6: Code 0x404F clears every code page, every executive page and every configuration byte. `id_q` is never cleared by any operation.
- R7: Code 0x404D clears code pages `NSEC` to `NPAGE-1` (the general segment) and configuration byte 0.
- R8: Code 0x404C clears all code pages and configuration bytes 0 and 1. Executive pages are left as they are.
- R9: Code 0x4042 clears one page chosen by the latched address. An address below `NPAGE` selects that code page. An address from `NPAGE` to `NPAGE+NEXEC-1` selects executive page (address − `NPAGE`). Any higher address clears nothing.
- R10: Code 0x4040 clears the configuration byte whose index is the latched address. An address of `NCFG` or more clears nothing.
- R11: The address used is the one held in the address register when the operation starts. Writes to the address register during the operation do not change the result.
- R12: Any other code with bit 15 set clears nothing and holds `busy` for exactly one cycle. `err` goes to 1 when that operation ends. `err` returns to 0 when the next operation starts.
- R13: Region flags change only at the edge where `busy` falls, or on `fill` while idle. `fill` sets every flag, including `id_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data; bit 15 starts an operation |
| adr_we | input | 1 | Address register write strobe |
| adr_wdata | input | ADDR_W | Page or configuration-byte index |
| fill | input | 1 | Model programming: mark every region as programmed |
| ctl_q | output | 16 | Current control word |
| busy | output | 1 | Operation in progress (same as bit 15) |
| err | output | 1 | Last operation had an unrecognised code |
| code_pg_q | output | NPAGE | Code page programmed flags |
| exec_pg_q | output | NEXEC | Executive page programmed flags |
| cfg_q | output | NCFG | Configuration byte programmed flags |
| id_q | output | 1 | Identity region programmed flag |

## Verification
The bench goes after the cases where the regions overlap.
- Secure erase must also clear the general segment but leave the executive pages alone. A decoder that treats it as a plain secure-only erase would leave the general pages set.
- Page addresses just past the code pages must land on executive pages. An off-by-one in the address split would hit the wrong page or none at all.
- Addresses past the last valid page must clear nothing.
- The address and control registers are rewritten during an operation. A design that reads the live address at completion would erase the wrong page. A design that accepts writes while busy would change the code or restart the timer, and that shows up as a wrong `ctl_q` or a wrong busy length.
- An unrecognised code must give exactly one busy cycle and set `err`. The bench also checks that the flag clears on the next start.

// File: rtl/nvm_erase_pkg.sv
package nvm_erase_pkg;

  localparam logic [14:0] OP_CHIP = 15'h404F;
  localparam logic [14:0] OP_GSEG = 15'h404D;
  localparam logic [14:0] OP_SSEG = 15'h404C;
  localparam logic [14:0] OP_PAGE = 15'h4042;
  localparam logic [14:0] OP_CFGB = 15'h4040;

  typedef enum logic [2:0] {
    K_BAD,
    K_CHIP,
    K_GSEG,
    K_SSEG,
    K_PAGE,
    K_CFGB
  } op_kind_e;

  function automatic op_kind_e classify(input logic [14:0] code);
    case (code)
      OP_CHIP: return K_CHIP;
      OP_GSEG: return K_GSEG;
      OP_SSEG: return K_SSEG;
      OP_PAGE: return K_PAGE;
      OP_CFGB: return K_CFGB;
      default: return K_BAD;
    endcase
  endfunction

endpackage

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
  import nvm_erase_pkg::*;
#(
  parameter int NPAGE  = 8,
  parameter int NSEC   = 2,
  parameter int NEXEC  = 2,
  parameter int NCFG   = 8,
  parameter int ADDR_W = 4,
  parameter int T_PAGE = 4,
  parameter int T_SEG  = 12,
  parameter int T_CHIP = 30,
  parameter int CNT_W  = 5
) (
  input  logic [14:0]       code,
  input  logic [ADDR_W-1:0] addr,
  output logic [NPAGE-1:0]  code_m,
  output logic [NEXEC-1:0]  exec_m,
  output logic [NCFG-1:0]   cfg_m,
  output logic [CNT_W-1:0]  dur,
  output logic              bad
);

  localparam logic [NPAGE-1:0] GEN_MASK = {NPAGE{1'b1}} << NSEC;

  logic [NPAGE-1:0] page_hit;
  logic [NEXEC-1:0] exec_hit;
  logic [NCFG-1:0]  cfg_hit;

  for (genvar i = 0; i < NPAGE; i++) begin : g_page
    assign page_hit[i] = (addr == ADDR_W'(i));
  end
  for (genvar j = 0; j < NEXEC; j++) begin : g_exec
    assign exec_hit[j] = (addr == ADDR_W'(NPAGE + j));
  end
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    assign cfg_hit[k] = (addr == ADDR_W'(k));
  end

  always_comb begin
    code_m = '0;
    exec_m = '0;
    cfg_m  = '0;
    dur    = CNT_W'(1);
    bad    = 1'b0;
    case (classify(code))
      K_CHIP: begin
        code_m = '1;
        exec_m = '1;
        cfg_m  = '1;
        dur    = CNT_W'(T_CHIP);
      end
      K_GSEG: begin
        code_m   = GEN_MASK;
        cfg_m[0] = 1'b1;
        dur      = CNT_W'(T_SEG);
      end
      K_SSEG: begin
        code_m   = '1;
        cfg_m[0] = 1'b1;
        cfg_m[1] = 1'b1;
        dur      = CNT_W'(T_SEG);
      end
      K_PAGE: begin
        code_m = page_hit;
        exec_m = exec_hit;
        dur    = CNT_W'(T_PAGE);
      end
      K_CFGB: begin
        cfg_m = cfg_hit;
        dur   = CNT_W'(T_PAGE);
      end
      default: bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/nvm_region_bank.sv
module nvm_region_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_all,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);

  logic [N-1:0] q_d;

  always_comb begin
    q_d = q;
    if (set_all)     q_d = '1;
    else if (clr_en) q_d = q & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/nvm_erase_ctrl.sv
module nvm_erase_ctrl #(
  parameter int NPAGE  = 8,
  parameter int NSEC   = 2,
  parameter int NEXEC  = 2,
  parameter int NCFG   = 8,
  parameter int ADDR_W = 4,
  parameter int T_PAGE = 4,
  parameter int T_SEG  = 12,
  parameter int T_CHIP = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_wdata,
  input  logic              adr_we,
  input  logic [ADDR_W-1:0] adr_wdata,
  input  logic              fill,
  output logic [15:0]       ctl_q,
  output logic              busy,
  output logic              err,
  output logic [NPAGE-1:0]  code_pg_q,
  output logic [NEXEC-1:0]  exec_pg_q,
  output logic [NCFG-1:0]   cfg_q,
  output logic              id_q
);

  localparam int CNT_W = $clog2(T_CHIP + 1);

  logic [15:0]       ctl_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic              accept, start, done, fill_ok;
  logic [NPAGE-1:0]  dec_code, pend_code;
  logic [NEXEC-1:0]  dec_exec, pend_exec;
  logic [NCFG-1:0]   dec_cfg,  pend_cfg;
  logic [CNT_W-1:0]  dec_dur;
  logic              dec_bad,  pend_bad;
  logic              err_d, id_d;

  assign busy    = ctl_q[15];
  assign accept  = ctl_we && !busy;
  assign start   = accept && ctl_wdata[15];
  assign fill_ok = fill && !busy;

  nvm_op_decode #(
    .NPAGE(NPAGE), .NSEC(NSEC), .NEXEC(NEXEC), .NCFG(NCFG),
    .ADDR_W(ADDR_W), .T_PAGE(T_PAGE), .T_SEG(T_SEG), .T_CHIP(T_CHIP),
    .CNT_W(CNT_W)
  ) dec_i (
    .code   (ctl_wdata[14:0]),
    .addr   (adr_q),
    .code_m (dec_code),
    .exec_m (dec_exec),
    .cfg_m  (dec_cfg),
    .dur    (dec_dur),
    .bad    (dec_bad)
  );

  nvm_busy_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (dec_dur),
    .done     (done)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (accept)           ctl_d = ctl_wdata;
    else if (done && busy) ctl_d = {1'b0, ctl_q[14:0]};
    adr_d = adr_we ? adr_wdata : adr_q;
    err_d = err;
    if (start)            err_d = 1'b0;
    else if (done && busy) err_d = pend_bad;
    id_d  = id_q | fill_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      adr_q <= '0;
      err   <= 1'b0;
      id_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      adr_q <= adr_d;
      err   <= err_d;
      id_q  <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code <= '0;
      pend_exec <= '0;
      pend_cfg  <= '0;
      pend_bad  <= 1'b0;
    end else if (start) begin
      pend_code <= dec_code;
      pend_exec <= dec_exec;
      pend_cfg  <= dec_cfg;
      pend_bad  <= dec_bad;
    end
  end

  nvm_region_bank #(.N(NPAGE)) code_bank_i (
    .clk(clk), .rst_n(rst_n), .set_all(fill_ok), .clr_en(done && busy),
    .clr_mask(pend_code), .q(code_pg_q)
  );
  nvm_region_bank #(.N(NEXEC)) exec_bank_i (
    .clk(clk), .rst_n(rst_n), .set_all(fill_ok), .clr_en(done && busy),
    .clr_mask(pend_exec), .q(exec_pg_q)
  );
  nvm_region_bank #(.N(NCFG)) cfg_bank_i (
    .clk(clk), .rst_n(rst_n), .set_all(fill_ok), .clr_en(done && busy),
    .clr_mask(pend_cfg), .q(cfg_q)
  );

endmodule

// File: rtl/nvm_erase_chk.sv
module nvm_erase_chk #(
  parameter int NPAGE  = 8,
  parameter int NEXEC  = 2,
  parameter int NCFG   = 8,
  parameter int T_PAGE = 4,
  parameter int T_SEG  = 12,
  parameter int T_CHIP = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [15:0]      ctl_q,
  input logic             busy,
  input logic             err,
  input logic [NPAGE-1:0] code_pg_q,
  input logic [NEXEC-1:0] exec_pg_q,
  input logic [NCFG-1:0]  cfg_q,
  input logic             id_q
);

  localparam logic [15:0] L_PAGE = 16'(T_PAGE);
  localparam logic [15:0] L_SEG  = 16'(T_SEG);
  localparam logic [15:0] L_CHIP = 16'(T_CHIP);

  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_len <= '0;
    else if (!busy)               run_len <= '0;
    else if (run_len != 16'hFFFF) run_len <= run_len + 16'd1;
  end

  // R4
  busy_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == L_PAGE || run_len == L_SEG ||
                     run_len == L_CHIP || run_len == 16'd1));

  // R3
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < L_CHIP));

  // R5
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we) |=> (ctl_q[14:0] == $past(ctl_q[14:0])));

  // R13
  clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|($past(code_pg_q) & ~code_pg_q)) || (|($past(exec_pg_q) & ~exec_pg_q)) ||
     (|($past(cfg_q) & ~cfg_q))) |-> $fell(busy));

  // R6
  id_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_q |=> id_q);

  // R12
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $fell(busy));

endmodule

bind nvm_erase_ctrl nvm_erase_chk #(
  .NPAGE(NPAGE), .NEXEC(NEXEC), .NCFG(NCFG),
  .T_PAGE(T_PAGE), .T_SEG(T_SEG), .T_CHIP(T_CHIP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_q(ctl_q), .busy(busy),
  .err(err), .code_pg_q(code_pg_q), .exec_pg_q(exec_pg_q), .cfg_q(cfg_q),
  .id_q(id_q)
);

// File: tb/nvm_erase_ctrl_tb_top.sv
module nvm_erase_ctrl_tb_top;

  localparam int NPAGE = 8, NSEC = 2, NEXEC = 2, NCFG = 8, ADDR_W = 4;
  localparam int T_PAGE = 4, T_SEG = 12, T_CHIP = 30;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_we = 1'b0;
  logic [15:0]       ctl_wdata = '0;
  logic              adr_we = 1'b0;
  logic [ADDR_W-1:0] adr_wdata = '0;
  logic              fill = 1'b0;
  logic [15:0]       ctl_q;
  logic              busy, err, id_q;
  logic [NPAGE-1:0]  code_pg_q;
  logic [NEXEC-1:0]  exec_pg_q;
  logic [NCFG-1:0]   cfg_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [NPAGE-1:0] m_code;
  logic [NEXEC-1:0] m_exec;
  logic [NCFG-1:0]  m_cfg;
  logic             m_id;

  always #5 clk = ~clk;

  nvm_erase_ctrl #(
    .NPAGE(NPAGE), .NSEC(NSEC), .NEXEC(NEXEC), .NCFG(NCFG), .ADDR_W(ADDR_W),
    .T_PAGE(T_PAGE), .T_SEG(T_SEG), .T_CHIP(T_CHIP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .adr_we(adr_we), .adr_wdata(adr_wdata), .fill(fill), .ctl_q(ctl_q),
    .busy(busy), .err(err), .code_pg_q(code_pg_q), .exec_pg_q(exec_pg_q),
    .cfg_q(cfg_q), .id_q(id_q)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_dur(input logic [14:0] c);
    case (c)
      15'h404F:           return T_CHIP;
      15'h404D, 15'h404C: return T_SEG;
      15'h4042, 15'h4040: return T_PAGE;
      default:            return 1;
    endcase
  endfunction

  function automatic bit is_bad(input logic [14:0] c);
    return exp_dur(c) == 1;
  endfunction

  task automatic model_apply(input logic [14:0] c, input int a);
    case (c)
      15'h404F: begin m_code = '0; m_exec = '0; m_cfg = '0; end
      15'h404D: begin
        for (int i = NSEC; i < NPAGE; i++) m_code[i] = 1'b0;
        m_cfg[0] = 1'b0;
      end
      15'h404C: begin m_code = '0; m_cfg[0] = 1'b0; m_cfg[1] = 1'b0; end
      15'h4042: begin
        if (a < NPAGE) m_code[a] = 1'b0;
        else if (a < NPAGE + NEXEC) m_exec[a - NPAGE] = 1'b0;
      end
      15'h4040: if (a < NCFG) m_cfg[a] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic cmp_flags(input string rq);
    chk(code_pg_q == m_code, {rq, " code pages"}, 32'(code_pg_q), 32'(m_code));
    chk(exec_pg_q == m_exec, {rq, " exec pages"}, 32'(exec_pg_q), 32'(m_exec));
    chk(cfg_q == m_cfg, {rq, " cfg bytes"}, 32'(cfg_q), 32'(m_cfg));
    chk(id_q == m_id, {rq, " id flag"}, 32'(id_q), 32'(m_id));
  endtask

  task automatic do_fill();
    @(negedge clk); fill = 1'b1;
    @(negedge clk); fill = 1'b0;
    m_code = '1; m_exec = '1; m_cfg = '1; m_id = 1'b1;
  endtask

  task automatic set_addr(input int a);
    @(negedge clk); adr_we = 1'b1; adr_wdata = ADDR_W'(a);
    @(negedge clk); adr_we = 1'b0;
  endtask

  // starts code c at address a; optional disturbance during busy
  task automatic run_op(input logic [14:0] c, input int a, input string rq,
                        input bit disturb);
    int n;
    set_addr(a);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = {1'b1, c};
    @(negedge clk); ctl_we = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", 32'(busy), 32'd1);
    chk(err == 1'b0, "R12 err cleared at start", 32'(err), 32'd0);
    cmp_flags("R13 unchanged while busy");
    if (disturb) begin
      adr_we = 1'b1; adr_wdata = ADDR_W'((a + 3) % 16);
      ctl_we = 1'b1; ctl_wdata = 16'hC04F;
      fill = 1'b1;
    end
    n = 0;
    while (busy && n < 100) begin
      @(negedge clk);
      adr_we = 1'b0; ctl_we = 1'b0; fill = 1'b0;
      n++;
    end
    chk(n == exp_dur(c), "R4 busy length", 32'(n), 32'(exp_dur(c)));
    chk(ctl_q == {1'b0, c}, "R3 code kept, start cleared", 32'(ctl_q),
        32'({1'b0, c}));
    chk(err == is_bad(c), "R12 err after op", 32'(err), 32'(is_bad(c)));
    model_apply(c, a);
    cmp_flags(rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [14:0] rc;
    int sel, ra;
    void'($urandom(32'd7021));
    m_code = '0; m_exec = '0; m_cfg = '0; m_id = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(ctl_q == 16'h0, "R1 ctl reset", 32'(ctl_q), 32'd0);
    chk(busy == 1'b0 && err == 1'b0, "R1 busy/err reset", 32'({busy, err}), 32'd0);
    cmp_flags("R1 flags reset");

    // R13 fill sets everything
    do_fill();
    cmp_flags("R13 fill");

    // R2 write without start bit
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 16'h404D;
    @(negedge clk); ctl_we = 1'b0;
    chk(ctl_q == 16'h404D, "R2 stored", 32'(ctl_q), 32'h404D);
    @(negedge clk);
    chk(busy == 1'b0, "R2 no start", 32'(busy), 32'd0);
    cmp_flags("R2 nothing erased");

    run_op(15'h404F, 0, "R6 chip erase", 1'b0);
    do_fill(); run_op(15'h404D, 0, "R7 general segment", 1'b0);
    do_fill(); run_op(15'h404C, 0, "R8 secure segment", 1'b0);
    do_fill();
    run_op(15'h4042, NPAGE - 1, "R9 last code page", 1'b0);
    run_op(15'h4042, NPAGE, "R9 first exec page", 1'b0);
    run_op(15'h4042, NPAGE + NEXEC, "R9 past end", 1'b0);
    run_op(15'h4040, 5, "R10 cfg byte", 1'b0);
    run_op(15'h4040, NCFG, "R10 cfg past end", 1'b0);

    // R11 and R5: rewrite address, control and fill during busy
    do_fill();
    run_op(15'h4042, 2, "R11 latched address", 1'b0);
    run_op(15'h4042, 3, "R5 R11 writes during busy ignored", 1'b1);

    // R12 unrecognised code
    run_op(15'h1234, 1, "R12 bad code", 1'b0);
    run_op(15'h4040, 0, "R12 err clears on next start", 1'b0);

    for (int it = 0; it < 60; it++) begin
      if ($urandom % 3 == 0) do_fill();
      sel = int'($urandom % 6);
      ra = int'($urandom % 16);
      case (sel)
        0: rc = 15'h404F;
        1: rc = 15'h404D;
        2: rc = 15'h404C;
        3: rc = 15'h4042;
        4: rc = 15'h4040;
        default: rc = 15'($urandom);
      endcase
      run_op(rc, ra, "R9 R10 random op", ($urandom % 4) == 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule